// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address and a result code, one fetch per cycle. It sits between the fetch unit and the instruction cache. It sends the virtual page number and the address space number to a translation buffer, which lives outside the block. It then combines the buffer's same-cycle answer with the current privilege mode and two bypass flags. The bypass flags are privileged-code execution and physical addressing.

Three address kinds skip the translation buffer:
- Privileged-code fetches take a word-aligned, width-masked copy of the virtual address.
- Physical-mode fetches use the virtual address unchanged.
- A fixed superpage window is mapped directly, for kernel mode only. Its physical result is sign extended from bit 40.

All other fetches go through the buffer and a per-mode read-enable check. Every physical result is also checked two ways. Any set bit above the implemented width is a machine check. A set bit 43 marks the result uncacheable, and because instruction fetches from I/O space are not allowed, that result is a fault.

The control is a two-state machine. `ST_IDLE` means no result is presented, and `ST_REPORT` means a registered result is on the outputs. The transitions are:
- `IDLE->REPORT`: taken on `fetch_valid`.
- `REPORT->REPORT`: taken on a back-to-back `fetch_valid`.
- `REPORT->IDLE`: taken when `fetch_valid` is low.
- `IDLE->IDLE`: taken when `fetch_valid` is low.

Three saturating counters count hits, misses and access violations.

Top module: `ift_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_code` is 0, `rsp_pa` is 0, `rsp_uncached` is 0 and all three counters are 0.
- R2: With `priv_code` set, the result is `rsp_pa = fetch_va[43:0]` with bits 1:0 cleared, code OK (0) and `rsp_uncached` 0. This takes priority over `phys_mode`, over the virtual-range check and over the translation buffer's answer.
- R3: With `phys_mode` set and `priv_code` clear, `rsp_pa = fetch_va[43:0]`. If any of `fetch_va[63:44]` is set, the code is machine check (3) and `rsp_uncached` is 0.
- R4: On the translated path, a virtual address whose bits 63:47 are not all equal gives access violation (1) with `rsp_pa` 0.
- R5: On the translated path, `fetch_va[47:41] == 7'h7E` selects the superpage window. In any mode other than kernel (mode code 0) the result is access violation. In kernel mode, `rsp_pa` is `{4'hF, va[39:0]}` when `va[40]` is 1 and `{4'h0, va[39:0]}` when it is 0.
- R6: A mapped fetch whose buffer answer has `tlb_hit` low gives page miss (2) with `rsp_pa` 0.
- R7: A mapped fetch with `tlb_hit` high requires `tlb_rd_en[cur_mode]` to be set; otherwise the result is access violation. The mode codes are kernel 0, executive 1, supervisor 2 and user 3. When the bit is set, `rsp_pa = {tlb_ppn, va[12:2], 2'b00}`.
- R8: A result on a non-privileged path that is below the implemented width and has bit 43 set sets `rsp_uncached` and gives the I/O-fetch fault code (4).
- R9: Results appear one clock after `fetch_valid` is sampled, and `rsp_valid` follows `fetch_valid` by one cycle. While `fetch_valid` is low, `rsp_pa`, `rsp_code`, `rsp_uncached` and the counters hold.
- R10: Each counter is incremented and saturates at all ones:
  - `hit_count` counts privileged-code fetches and permitted mapped hits, including a hit that then faults as I/O.
  - `miss_count` counts page misses.
  - `acv_count` counts access violations.
- R11: `tlb_vpn` carries `fetch_va[47:13]` and `tlb_asn` carries `cur_asn`, both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_va | input | VA_W (64) | Fetch virtual address |
| priv_code | input | 1 | Fetch comes from privileged code; bypass translation |
| phys_mode | input | 1 | Treat the address as physical |
| cur_mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| cur_asn | input | ASN_W (8) | Current address space number |
| tlb_vpn | output | VPN_W (35) | Page number sent to the translation buffer |
| tlb_asn | output | ASN_W (8) | Address space number sent to the buffer |
| tlb_hit | input | 1 | Buffer found a matching entry |
| tlb_ppn | input | PPN_W (31) | Physical page number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables of the entry, indexed by mode code |
| rsp_valid | output | 1 | Registered result is valid |
| rsp_pa | output | PA_W (44) | Physical address |
| rsp_code | output | 3 | 0 OK, 1 access violation, 2 page miss, 3 machine check, 4 I/O fetch fault |
| rsp_uncached | output | 1 | Result lies in uncacheable space |
| hit_count | output | CNT_W (32) | Saturating hit count |
| miss_count | output | CNT_W (32) | Saturating miss count |
| acv_count | output | CNT_W (32) | Saturating access-violation count |

## Verification
`tlb_vpn` and `tlb_asn` are combinational, so the bench checks them while the fetch inputs are still driven, before any clock edge. All translated results and the counters pass through exactly one register. The bench therefore drives each fetch at a falling edge and samples one nanosecond after the next rising edge, which is the first point at which the new result is visible. The hold checks let two further rising edges pass with `fetch_valid` low and new input values, then confirm that nothing on the outputs moved.

// File: rtl/ift_pkg.sv
package ift_pkg;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_ACV     = 3'd1,
        RC_MISS    = 3'd2,
        RC_MCHK    = 3'd3,
        RC_IOFETCH = 3'd4
    } xl_result_e;

    typedef enum logic [1:0] {
        PM_KERNEL = 2'd0,
        PM_EXEC   = 2'd1,
        PM_SUPER  = 2'd2,
        PM_USER   = 2'd3
    } priv_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } xl_state_e;

endpackage

// File: rtl/ift_va_classify.sv
// Decides whether a virtual address is in the legal range and whether it
// falls into the direct-mapped superpage window.
module ift_va_classify #(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 48,
    parameter int SP_LO   = 41,
    parameter int SP_TAG  = 'h7E
) (
    input  logic [VA_W-1:SP_LO] va_hi,
    output logic                va_ok,
    output logic                is_super
);
    localparam int SIGN_LO = VA_IMPL - 1;
    localparam int TAG_W   = VA_IMPL - SP_LO;

    logic [VA_W-1:SIGN_LO] sign_bits;

    always_comb begin
        sign_bits = va_hi[VA_W-1:SIGN_LO];
        va_ok     = (&sign_bits) | ~(|sign_bits);
        is_super  = (va_hi[VA_IMPL-1:SP_LO] == TAG_W'(SP_TAG));
    end
endmodule

// File: rtl/ift_pa_form.sv
// Builds the physical address and the result code for one fetch.
module ift_pa_form
    import ift_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PA_W    = 44,
    parameter int PG_OFS  = 13,
    parameter int SX_BIT  = 40,
    parameter int UNC_BIT = 43,
    parameter int MODES   = 4
) (
    input  logic [VA_W-1:0]        va,
    input  logic                   priv_code,
    input  logic                   phys_mode,
    input  logic [1:0]             mode,
    input  logic                   va_ok,
    input  logic                   is_super,
    input  logic                   tlb_hit,
    input  logic [PA_W-PG_OFS-1:0] tlb_ppn,
    input  logic [MODES-1:0]       tlb_rd_en,
    output logic [PA_W-1:0]        pa,
    output xl_result_e             code,
    output logic                   uncached,
    output logic                   hit_ev
);
    localparam logic [PA_W-1:0] HI_MASK = {PA_W{1'b1}} << SX_BIT;

    logic [VA_W-1:0] cand;
    logic            check_pa;
    logic [PA_W-1:0] sp_base;
    logic [PA_W-1:0] mapped;

    always_comb begin
        sp_base  = va[PA_W-1:0];
        mapped   = {tlb_ppn, va[PG_OFS-1:2], 2'b00};
        cand     = '0;
        check_pa = 1'b0;
        pa       = '0;
        code     = RC_OK;
        uncached = 1'b0;
        hit_ev   = 1'b0;

        if (priv_code) begin
            pa     = {va[PA_W-1:2], 2'b00};
            hit_ev = 1'b1;
        end else begin
            if (phys_mode) begin
                cand     = va;
                check_pa = 1'b1;
            end else if (!va_ok) begin
                code = RC_ACV;
            end else if (is_super) begin
                if (mode != PM_KERNEL) begin
                    code = RC_ACV;
                end else begin
                    cand = {{(VA_W-PA_W){1'b0}},
                            sp_base[SX_BIT] ? (sp_base | HI_MASK)
                                            : (sp_base & ~HI_MASK)};
                    check_pa = 1'b1;
                end
            end else if (!tlb_hit) begin
                code = RC_MISS;
            end else if (!tlb_rd_en[mode]) begin
                code = RC_ACV;
            end else begin
                cand     = {{(VA_W-PA_W){1'b0}}, mapped};
                hit_ev   = 1'b1;
                check_pa = 1'b1;
            end

            if (check_pa) begin
                pa = cand[PA_W-1:0];
                if (|cand[VA_W-1:PA_W]) begin
                    code = RC_MCHK;
                end else if (cand[UNC_BIT]) begin
                    uncached = 1'b1;
                    code     = RC_IOFETCH;
                end
            end
        end
    end
endmodule

// File: rtl/ift_sat_cnt.sv
// Event counter that stops at its maximum value.
module ift_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (bump && (value != '1)) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/ift_xlate.sv
// Instruction fetch translation stage: classification and address forming
// are combinational, results and counters are registered.
module ift_xlate
    import ift_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 48,
    parameter int PA_W    = 44,
    parameter int PG_OFS  = 13,
    parameter int SP_LO   = 41,
    parameter int SP_TAG  = 'h7E,
    parameter int SX_BIT  = 40,
    parameter int UNC_BIT = 43,
    parameter int ASN_W   = 8,
    parameter int CNT_W   = 32,
    parameter int MODES   = 4,
    localparam int PPN_W  = PA_W - PG_OFS,
    localparam int VPN_W  = VA_IMPL - PG_OFS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [VA_W-1:0]  fetch_va,
    input  logic             priv_code,
    input  logic             phys_mode,
    input  logic [1:0]       cur_mode,
    input  logic [ASN_W-1:0] cur_asn,
    output logic [VPN_W-1:0] tlb_vpn,
    output logic [ASN_W-1:0] tlb_asn,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    input  logic [MODES-1:0] tlb_rd_en,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [2:0]       rsp_code,
    output logic             rsp_uncached,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count,
    output logic [CNT_W-1:0] acv_count
);
    localparam int NUM_CNT = 3;
    localparam int CI_HIT  = 0;
    localparam int CI_MISS = 1;
    localparam int CI_ACV  = 2;

    xl_state_e        state_q, state_d;
    logic             va_ok, is_super;
    logic [PA_W-1:0]  pa_c;
    xl_result_e       code_c;
    logic             unc_c, hit_ev_c;
    logic [NUM_CNT-1:0] bump;
    logic [CNT_W-1:0] cnt_val [NUM_CNT];

    // Lookup request to the external translation buffer.
    assign tlb_vpn = fetch_va[VA_IMPL-1:PG_OFS];
    assign tlb_asn = cur_asn;

    ift_va_classify #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
    ) u_cls (
        .va_hi    (fetch_va[VA_W-1:SP_LO]),
        .va_ok    (va_ok),
        .is_super (is_super)
    );

    ift_pa_form #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_OFS(PG_OFS),
        .SX_BIT(SX_BIT), .UNC_BIT(UNC_BIT), .MODES(MODES)
    ) u_form (
        .va        (fetch_va),
        .priv_code (priv_code),
        .phys_mode (phys_mode),
        .mode      (cur_mode),
        .va_ok     (va_ok),
        .is_super  (is_super),
        .tlb_hit   (tlb_hit),
        .tlb_ppn   (tlb_ppn),
        .tlb_rd_en (tlb_rd_en),
        .pa        (pa_c),
        .code      (code_c),
        .uncached  (unc_c),
        .hit_ev    (hit_ev_c)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = fetch_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = fetch_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers, loaded on each accepted fetch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_pa       <= '0;
            rsp_code     <= RC_OK;
            rsp_uncached <= 1'b0;
        end else if (fetch_valid) begin
            rsp_pa       <= pa_c;
            rsp_code     <= code_c;
            rsp_uncached <= unc_c;
        end
    end

    assign rsp_valid = (state_q == ST_REPORT);

    always_comb begin
        bump          = '0;
        bump[CI_HIT]  = fetch_valid && hit_ev_c;
        bump[CI_MISS] = fetch_valid && (code_c == RC_MISS);
        bump[CI_ACV]  = fetch_valid && (code_c == RC_ACV);
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        ift_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .bump  (bump[g]),
            .value (cnt_val[g])
        );
    end

    assign hit_count  = cnt_val[CI_HIT];
    assign miss_count = cnt_val[CI_MISS];
    assign acv_count  = cnt_val[CI_ACV];
endmodule

// File: rtl/ift_xlate_chk.sv
module ift_xlate_chk
    import ift_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PA_W  = 44,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic [VA_W-1:0]  fetch_va,
    input logic             priv_code,
    input logic             phys_mode,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_pa,
    input logic [2:0]       rsp_code,
    input logic             rsp_uncached,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count,
    input logic [CNT_W-1:0] acv_count
);
    p_idle_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> !rsp_valid);

    p_priv_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && priv_code |=>
            (rsp_code == RC_OK) && !rsp_uncached && (rsp_pa[1:0] == 2'b00));

    p_phys_mchk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !priv_code && phys_mode && (|fetch_va[VA_W-1:PA_W])
            |=> (rsp_code == RC_MCHK) && !rsp_uncached);

    p_uncached_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_uncached |-> rsp_code == RC_IOFETCH);

    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> rsp_valid);

    p_rsp_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !rsp_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(rsp_pa) && $stable(rsp_code) &&
            $stable(rsp_uncached) && $stable(hit_count) &&
            $stable(miss_count) && $stable(acv_count));

    p_hit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> CNT_W'(hit_count - $past(hit_count)) <= CNT_W'(1));

    p_miss_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> CNT_W'(miss_count - $past(miss_count)) <= CNT_W'(1));

    p_acv_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> CNT_W'(acv_count - $past(acv_count)) <= CNT_W'(1));
endmodule

bind ift_xlate ift_xlate_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_va     (fetch_va),
    .priv_code    (priv_code),
    .phys_mode    (phys_mode),
    .rsp_valid    (rsp_valid),
    .rsp_pa       (rsp_pa),
    .rsp_code     (rsp_code),
    .rsp_uncached (rsp_uncached),
    .hit_count    (hit_count),
    .miss_count   (miss_count),
    .acv_count    (acv_count)
);

// File: tb/tb_ift_xlate.sv
`timescale 1ns/1ps
module tb_ift_xlate;
    localparam int CW = 4;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [2:0] C_OK = 3'd0, C_ACV = 3'd1, C_MISS = 3'd2,
                           C_MCHK = 3'd3, C_IO = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_va = '0;
    logic        priv_code = 1'b0, phys_mode = 1'b0;
    logic [1:0]  cur_mode = 2'd0;
    logic [7:0]  cur_asn = 8'h00;
    logic [34:0] tlb_vpn;
    logic [7:0]  tlb_asn;
    logic        tlb_hit = 1'b0;
    logic [30:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = 4'h0;
    logic        rsp_valid, rsp_uncached;
    logic [43:0] rsp_pa;
    logic [2:0]  rsp_code;
    logic [CW-1:0] hit_count, miss_count, acv_count;

    int n_chk = 0, n_fail = 0;
    logic [CW-1:0] e_hit = '0, e_miss = '0, e_acv = '0;

    always #2 clk = ~clk;

    ift_xlate #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_va(fetch_va),
        .priv_code(priv_code), .phys_mode(phys_mode), .cur_mode(cur_mode),
        .cur_asn(cur_asn), .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_code(rsp_code), .rsp_uncached(rsp_uncached),
        .hit_count(hit_count), .miss_count(miss_count), .acv_count(acv_count)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == CMAX) ? v : v + 1'b1;
    endfunction

    task automatic check_counts(input string req);
        check(req, "hit_count", 64'(hit_count), 64'(e_hit));
        check(req, "miss_count", 64'(miss_count), 64'(e_miss));
        check(req, "acv_count", 64'(acv_count), 64'(e_acv));
    endtask

    // One fetch: drive at falling edge, sample 1 ns after the capturing edge.
    task automatic fetch(input logic [63:0] va, input logic pc, input logic ph,
                         input logic [1:0] md, input logic hit,
                         input logic [30:0] ppn, input logic [3:0] rd);
        @(negedge clk);
        fetch_va = va; priv_code = pc; phys_mode = ph; cur_mode = md;
        tlb_hit = hit; tlb_ppn = ppn; tlb_rd_en = rd; fetch_valid = 1'b1;
        @(posedge clk); #1;
        fetch_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic [2:0] code,
                              input logic [43:0] pa, input logic unc);
        check(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        check(req, "rsp_code", 64'(rsp_code), 64'(code));
        check(req, "rsp_pa", 64'(rsp_pa), 64'(pa));
        check(req, "rsp_uncached", 64'(rsp_uncached), 64'(unc));
    endtask

    task automatic t_reset();
        check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1", "rsp_code", 64'(rsp_code), 64'd0);
        check("R1", "rsp_pa", 64'(rsp_pa), 64'd0);
        check("R1", "rsp_uncached", 64'(rsp_uncached), 64'd0);
        check_counts("R1");
    endtask

    task automatic t_priv();
        // R2: invalid VA, physical flag and TLB miss are all overridden.
        fetch(64'h0001_F000_1234_5677, 1'b1, 1'b1, 2'd3, 1'b0, '0, 4'h0);
        e_hit = sat_inc(e_hit);
        expect_rsp("R2", C_OK, 44'h000_1234_5674, 1'b0);
        check_counts("R2");
    endtask

    task automatic t_phys();
        fetch(64'h0000_0000_1234_5678, 1'b0, 1'b1, 2'd3, 1'b0, '0, 4'h0);
        expect_rsp("R3", C_OK, 44'h000_1234_5678, 1'b0);
        fetch(64'h0004_0000_0000_1000, 1'b0, 1'b1, 2'd0, 1'b0, '0, 4'h0);
        expect_rsp("R3", C_MCHK, 44'h000_0000_1000, 1'b0);
        // R8: bit 43 set, within width.
        fetch(64'h0000_0800_0000_1000, 1'b0, 1'b1, 2'd0, 1'b0, '0, 4'h0);
        expect_rsp("R8", C_IO, 44'h800_0000_1000, 1'b1);
        check_counts("R3");
    endtask

    task automatic t_badva();
        fetch(64'h0001_0000_0000_0000, 1'b0, 1'b0, 2'd0, 1'b1, 31'h1, 4'hF);
        e_acv = sat_inc(e_acv);
        expect_rsp("R4", C_ACV, 44'h0, 1'b0);
        check_counts("R4");
    endtask

    task automatic t_super();
        fetch(64'hFFFF_FC00_1234_5678, 1'b0, 1'b0, 2'd0, 1'b0, '0, 4'h0);
        expect_rsp("R5", C_OK, 44'h000_1234_5678, 1'b0);
        fetch(64'hFFFF_FD00_0000_4000, 1'b0, 1'b0, 2'd0, 1'b0, '0, 4'h0);
        expect_rsp("R5", C_IO, 44'hF00_0000_4000, 1'b1);
        fetch(64'hFFFF_FC00_1234_5678, 1'b0, 1'b0, 2'd3, 1'b1, 31'h7, 4'hF);
        e_acv = sat_inc(e_acv);
        expect_rsp("R5", C_ACV, 44'h0, 1'b0);
        check_counts("R5");
    endtask

    task automatic t_mapped();
        logic [63:0] va = 64'h0000_1234_5640_3A5F;
        fetch(va, 1'b0, 1'b0, 2'd0, 1'b1, 31'h0000_1ABC, 4'b0001);
        e_hit = sat_inc(e_hit);
        expect_rsp("R7", C_OK, {31'h0000_1ABC, va[12:2], 2'b00}, 1'b0);
        check("R11", "tlb_vpn", 64'(tlb_vpn), 64'(va[47:13]));
        cur_asn = 8'h5C; #1;
        check("R11", "tlb_asn", 64'(tlb_asn), 64'h5C);
        fetch(va, 1'b0, 1'b0, 2'd3, 1'b1, 31'h0000_1ABC, 4'b0111);
        e_acv = sat_inc(e_acv);
        expect_rsp("R7", C_ACV, 44'h0, 1'b0);
        fetch(va, 1'b0, 1'b0, 2'd2, 1'b1, 31'h0000_0042, 4'b0100);
        e_hit = sat_inc(e_hit);
        expect_rsp("R7", C_OK, {31'h0000_0042, va[12:2], 2'b00}, 1'b0);
        fetch(va, 1'b0, 1'b0, 2'd0, 1'b0, 31'h0000_1ABC, 4'hF);
        e_miss = sat_inc(e_miss);
        expect_rsp("R6", C_MISS, 44'h0, 1'b0);
        // R8 and R10: permitted hit into I/O space still counts as a hit.
        fetch(va, 1'b0, 1'b0, 2'd1, 1'b1, 31'h4000_0001, 4'b0010);
        e_hit = sat_inc(e_hit);
        expect_rsp("R8", C_IO, {31'h4000_0001, va[12:2], 2'b00}, 1'b1);
        check_counts("R10");
    endtask

    task automatic t_hold();
        logic [43:0] pa_before;
        fetch(64'h0000_0000_0000_2004, 1'b0, 1'b1, 2'd0, 1'b0, '0, 4'h0);
        pa_before = rsp_pa;
        @(negedge clk);
        fetch_va = 64'h0000_0000_0000_0000; priv_code = 1'b1; tlb_hit = 1'b0;
        phys_mode = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R9", "rsp_valid low", 64'(rsp_valid), 64'd0);
        check("R9", "rsp_pa held", 64'(rsp_pa), 64'(pa_before));
        check("R9", "rsp_code held", 64'(rsp_code), 64'(C_OK));
        check_counts("R9");
        // Back-to-back fetches.
        @(negedge clk);
        priv_code = 1'b0; phys_mode = 1'b1;
        fetch_va = 64'h0000_0000_0000_0100; fetch_valid = 1'b1;
        @(negedge clk);
        fetch_va = 64'h0000_0000_0000_0200;
        @(posedge clk); #1;
        fetch_valid = 1'b0;
        expect_rsp("R9", C_OK, 44'h200, 1'b0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 20; i++) begin
            fetch(64'h0000_0000_0000_1000, 1'b1, 1'b0, 2'd0, 1'b0, '0, 4'h0);
            e_hit = sat_inc(e_hit);
        end
        check("R10", "hit_count saturated", 64'(hit_count), 64'(CMAX));
        check_counts("R10");
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_priv();
        t_phys();
        t_badva();
        t_super();
        t_mapped();
        t_hold();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule